// File: doc/BRIEF.md
# Block Readout Sequencer with Token Chaining

This block streams stored 12-bit conversion results onto a shared output bus, one word per read-clock cycle. The results sit in a synchronous memory of five channels of 256 words each. The block reads that memory through a request port and turns each returned word into a bus word. A 3-bit channel code chooses the channel. A 3-bit block code chooses one quarter of that channel, a run of 64 words, so that parts of the record known to hold nothing useful can be skipped.

Several devices can share one bus. A device does nothing until a token pulse arrives on its input. It then runs the command given by the two codes. When a readout ends, or when no readout was asked for, it passes a token pulse to the next device in the chain. Some code values stand for clear commands, each emitted as a one-cycle pulse, instead of readouts. The bus enable is active low. When the bus is not driven, the block holds its tri-state enable low and its data lines at zero.

Top module: `blkread_seq`

## Requirements
- R1: While reset is held and on the first cycle after it is released, rd_en, bus_valid, bus_oe, tok_out, clr_mon, clr_tok and clr_trig are all 0.
- R2: A token with channel code c in 1..5 and block code b in 1..4 reads 64 words in ascending order. The words come from memory addresses (c-1)*256 + (b-1)*64 + i for i = 0..63, channel-major.
- R3: rd_en is high for exactly 64 consecutive cycles. The first of them is the cycle after the edge that samples tok_in, and rd_addr carries the first address in that cycle. Memory data returns one cycle after its request.
- R4: Each word is on the bus with bus_valid high two cycles after its request, one word per cycle with no gaps.
- R5: tok_out is high for exactly one cycle, the cycle after the last word of a readout leaves the bus.
- R6: With oe_n high, bus_oe and bus_data are 0. With oe_n low and bus_valid high, bus_oe is 1 and bus_data carries the word. oe_n never stalls or reorders the readout.
- R7: Channel code 6 gives a one-cycle clr_mon pulse in the cycle after the token is sampled. No readout starts, and the token is passed in that same cycle.
- R8: Block code 5 gives a one-cycle clr_tok pulse and block code 6 a one-cycle clr_trig pulse, each in the cycle after the token is sampled. No readout starts, and the token is passed in that same cycle.
- R9: Channel code 0 or block code 0, with neither code 7, starts no readout and passes the token: tok_out is high for one cycle, the cycle after the token is sampled.
- R10: Code 7 in either field makes the token do nothing: no readout, no clear pulse and no tok_out.
- R11: A token that arrives while a readout is running is ignored. It starts no readout, gives no clear pulse and does not change the words being read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous reset, active high |
| tok_in | input | 1 | Token pulse from the previous device in the chain |
| chan_sel | input | 3 | Channel code: 0 none, 1-5 channel, 6 clear monitor, 7 ignored |
| blk_code | input | 3 | Block code: 0 none, 1-4 block, 5 clear token, 6 clear trigger, 7 ignored |
| oe_n | input | 1 | Bus output enable, active low |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 11 | Memory read address, channel-major |
| rd_data | input | 12 | Memory read data, one cycle after the request |
| bus_data | output | 12 | Bus data, zero when not driven |
| bus_oe | output | 1 | Tri-state enable for the bus pads |
| bus_valid | output | 1 | A readout word occupies the bus stage |
| tok_out | output | 1 | Token pulse to the next device |
| clr_mon | output | 1 | Pulse to clear the oscillator monitor counter |
| clr_tok | output | 1 | Pulse to clear the token logic |
| clr_trig | output | 1 | Pulse to clear the trigger responses |

## Verification
On every cycle the assertions check the following. Addresses step by one within a readout, and the request run stops after exactly one block. Each returned word reaches the bus stage one cycle later. tok_out follows the last word. A token while busy or a token carrying code 7 has no effect, and channel code 6 always yields a monitor clear. Only the bench scenarios show the rest: that the first address is placed correctly for a given channel and block, that the data values seen at the pads match memory contents, how the enable gates the pads cycle by cycle, and the exact cycles of the pulses for each command code.

// File: rtl/blkread_pkg.sv
package blkread_pkg;

    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] CODE_NONE   = 3'd0;
    localparam logic [CODE_W-1:0] CODE_IGNORE = 3'd7;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_READ
    } seq_state_e;

    typedef struct packed {
        logic go;
        logic pass;
        logic clr_mon;
        logic clr_tok;
        logic clr_trig;
    } tok_cmd_t;

    function automatic logic code_in_range(input logic [CODE_W-1:0] code,
                                           input logic [CODE_W-1:0] hi);
        return (code != CODE_NONE) && (code <= hi);
    endfunction

endpackage

// File: rtl/blkread_decode.sv
module blkread_decode
    import blkread_pkg::*;
#(
    parameter int N_CHAN = 5,
    parameter int N_BLK  = 4,
    parameter int CELLS  = 256,
    parameter int ADDR_W = 11
) (
    input  logic [CODE_W-1:0] chan_sel,
    input  logic [CODE_W-1:0] blk_code,
    output tok_cmd_t          cmd,
    output logic [ADDR_W-1:0] base_addr
);
    localparam int BLK_LEN = CELLS / N_BLK;
    localparam logic [CODE_W-1:0] CH_MAX      = CODE_W'(N_CHAN);
    localparam logic [CODE_W-1:0] CH_CLR_MON  = CODE_W'(N_CHAN + 1);
    localparam logic [CODE_W-1:0] BK_MAX      = CODE_W'(N_BLK);
    localparam logic [CODE_W-1:0] BK_CLR_TOK  = CODE_W'(N_BLK + 1);
    localparam logic [CODE_W-1:0] BK_CLR_TRIG = CODE_W'(N_BLK + 2);

    logic              ign;
    logic              ch_ok;
    logic              bk_ok;
    logic [CODE_W-1:0] ch_m1;
    logic [CODE_W-1:0] bk_m1;

    always_comb begin
        ign   = (chan_sel == CODE_IGNORE) || (blk_code == CODE_IGNORE);
        ch_ok = code_in_range(chan_sel, CH_MAX);
        bk_ok = code_in_range(blk_code, BK_MAX);

        cmd.go       = !ign && ch_ok && bk_ok;
        cmd.pass     = !ign && !(ch_ok && bk_ok);
        cmd.clr_mon  = !ign && (chan_sel == CH_CLR_MON);
        cmd.clr_tok  = !ign && (blk_code == BK_CLR_TOK);
        cmd.clr_trig = !ign && (blk_code == BK_CLR_TRIG);

        ch_m1     = chan_sel - CODE_W'(1);
        bk_m1     = blk_code - CODE_W'(1);
        base_addr = ADDR_W'(ch_m1) * ADDR_W'(CELLS)
                  + ADDR_W'(bk_m1) * ADDR_W'(BLK_LEN);
    end

endmodule

// File: rtl/blkread_ctrl.sv
module blkread_ctrl
    import blkread_pkg::*;
#(
    parameter int BLK_LEN = 64,
    parameter int ADDR_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_in,
    input  tok_cmd_t          cmd,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_last,
    output logic              busy,
    output logic              pass_q,
    output logic              clr_mon,
    output logic              clr_tok,
    output logic              clr_trig
);
    localparam int CNT_W = $clog2(BLK_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLK_LEN - 1);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            cnt_q    <= '0;
            addr_q   <= '0;
            pass_q   <= 1'b0;
            clr_mon  <= 1'b0;
            clr_tok  <= 1'b0;
            clr_trig <= 1'b0;
        end else begin
            pass_q   <= 1'b0;
            clr_mon  <= 1'b0;
            clr_tok  <= 1'b0;
            clr_trig <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (tok_in) begin
                        pass_q   <= cmd.pass;
                        clr_mon  <= cmd.clr_mon;
                        clr_tok  <= cmd.clr_tok;
                        clr_trig <= cmd.clr_trig;
                        if (cmd.go) begin
                            state_q <= SEQ_READ;
                            cnt_q   <= '0;
                            addr_q  <= base_addr;
                        end
                    end
                end
                SEQ_READ: begin
                    cnt_q  <= cnt_q + CNT_W'(1);
                    addr_q <= addr_q + ADDR_W'(1);
                    if (cnt_q == LAST_IDX) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state_q == SEQ_READ);
        rd_en   = busy;
        rd_addr = addr_q;
        rd_last = busy && (cnt_q == LAST_IDX);
    end

    // R2: consecutive requests step the address by one
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en && !rd_last |=> rd_en && (rd_addr == $past(rd_addr) + ADDR_W'(1)));

    // R3: the request run ends right after the last block word
    assert_blk_len_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_last |=> !rd_en);

    // R11: a token seen while reading produces no command
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        busy && tok_in |=> !pass_q && !clr_mon && !clr_tok && !clr_trig);

endmodule

// File: rtl/blkread_out.sv
module blkread_out #(
    parameter int WORD_W = 12,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_last,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              oe_n,
    input  logic              pass_q,
    output logic [WORD_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              bus_valid,
    output logic              tok_out
);
    logic [RD_LAT-1:0] v_sr;
    logic [RD_LAT-1:0] l_sr;
    logic              rsp_v;
    logic              rsp_l;
    logic [WORD_W-1:0] bus_q;
    logic              bus_v;
    logic              bus_l;
    logic              end_tok;

    generate
        if (RD_LAT == 1) begin : g_lat_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_sr <= '0;
                    l_sr <= '0;
                end else begin
                    v_sr[0] <= rd_en;
                    l_sr[0] <= rd_last;
                end
            end
        end else begin : g_lat_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_sr <= '0;
                    l_sr <= '0;
                end else begin
                    v_sr <= {v_sr[RD_LAT-2:0], rd_en};
                    l_sr <= {l_sr[RD_LAT-2:0], rd_last};
                end
            end
        end
    endgenerate

    assign rsp_v = v_sr[RD_LAT-1];
    assign rsp_l = l_sr[RD_LAT-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q   <= '0;
            bus_v   <= 1'b0;
            bus_l   <= 1'b0;
            end_tok <= 1'b0;
        end else begin
            bus_q   <= rsp_v ? rd_data : '0;
            bus_v   <= rsp_v;
            bus_l   <= rsp_v && rsp_l;
            end_tok <= bus_v && bus_l;
        end
    end

    always_comb begin
        bus_valid = bus_v;
        bus_oe    = bus_v && !oe_n;
        bus_data  = bus_oe ? bus_q : '0;
        tok_out   = end_tok || pass_q;
    end

    // R4: every returned word lands in the bus stage one cycle later
    assert_word_stage_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_v |=> bus_v && (bus_q == $past(rd_data)));

    // R5: the token follows the final word
    assert_tok_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        bus_v && bus_l |=> tok_out);

endmodule

// File: rtl/blkread_seq.sv
module blkread_seq
    import blkread_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int N_CHAN = 5,
    parameter int N_BLK  = 4,
    parameter int CELLS  = 256,
    parameter int RD_LAT = 1,
    localparam int ADDR_W  = $clog2(N_CHAN * CELLS),
    localparam int BLK_LEN = CELLS / N_BLK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_in,
    input  logic [2:0]        chan_sel,
    input  logic [2:0]        blk_code,
    input  logic              oe_n,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              bus_valid,
    output logic              tok_out,
    output logic              clr_mon,
    output logic              clr_tok,
    output logic              clr_trig
);
    tok_cmd_t          cmd;
    logic [ADDR_W-1:0] base_addr;
    logic              rd_last;
    logic              busy;
    logic              pass_q;

    blkread_decode #(
        .N_CHAN (N_CHAN),
        .N_BLK  (N_BLK),
        .CELLS  (CELLS),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .chan_sel  (chan_sel),
        .blk_code  (blk_code),
        .cmd       (cmd),
        .base_addr (base_addr)
    );

    blkread_ctrl #(
        .BLK_LEN (BLK_LEN),
        .ADDR_W  (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tok_in    (tok_in),
        .cmd       (cmd),
        .base_addr (base_addr),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_last   (rd_last),
        .busy      (busy),
        .pass_q    (pass_q),
        .clr_mon   (clr_mon),
        .clr_tok   (clr_tok),
        .clr_trig  (clr_trig)
    );

    blkread_out #(
        .WORD_W (WORD_W),
        .RD_LAT (RD_LAT)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_last   (rd_last),
        .rd_data   (rd_data),
        .oe_n      (oe_n),
        .pass_q    (pass_q),
        .bus_data  (bus_data),
        .bus_oe    (bus_oe),
        .bus_valid (bus_valid),
        .tok_out   (tok_out)
    );

    // R10: a code of 7 in either field leaves everything quiet
    assert_ignore_seven_R10: assert property (@(posedge clk) disable iff (rst)
        !busy && tok_in && (chan_sel == CODE_IGNORE || blk_code == CODE_IGNORE)
        |=> !rd_en && !pass_q && !clr_mon && !clr_tok && !clr_trig);

    // R7: channel code 6 on an idle token always clears the monitor
    assert_monitor_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !busy && tok_in && (chan_sel == 3'd6) && (blk_code != CODE_IGNORE)
        |=> clr_mon && !rd_en);

endmodule

// File: tb/blkread_seq_tb.sv
module blkread_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tok_in = 1'b0;
    logic [2:0]  chan_sel = 3'd0;
    logic [2:0]  blk_code = 3'd0;
    logic        oe_n = 1'b0;
    logic        rd_en;
    logic [10:0] rd_addr;
    logic [11:0] rd_data = 12'd0;
    logic [11:0] bus_data;
    logic        bus_oe;
    logic        bus_valid;
    logic        tok_out;
    logic        clr_mon;
    logic        clr_tok;
    logic        clr_trig;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    blkread_seq dut_i (
        .clk       (clk),
        .rst       (rst),
        .tok_in    (tok_in),
        .chan_sel  (chan_sel),
        .blk_code  (blk_code),
        .oe_n      (oe_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .bus_data  (bus_data),
        .bus_oe    (bus_oe),
        .bus_valid (bus_valid),
        .tok_out   (tok_out),
        .clr_mon   (clr_mon),
        .clr_tok   (clr_tok),
        .clr_trig  (clr_trig)
    );

    function automatic logic [11:0] mem_word(input logic [10:0] a);
        return 12'(a) * 12'd7 + 12'd3;
    endfunction

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem_word(rd_addr);
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic quiet_outputs(input string tag);
        check({tag, " rd_en"}, 32'(rd_en), 0);
        check({tag, " bus_valid"}, 32'(bus_valid), 0);
        check({tag, " bus_oe"}, 32'(bus_oe), 0);
        check({tag, " tok_out"}, 32'(tok_out), 0);
        check({tag, " clears"}, 32'({clr_mon, clr_tok, clr_trig}), 0);
    endtask

    // leaves the bench at the falling edge after the sampling edge
    task automatic send_token(input logic [2:0] c, input logic [2:0] b);
        @(negedge clk);
        chan_sel = c;
        blk_code = b;
        tok_in   = 1'b1;
        @(negedge clk);
        tok_in   = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        quiet_outputs("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        quiet_outputs("R1 after reset");
    endtask

    task automatic t_read(input logic [2:0] c, input logic [2:0] b,
                          input bit toggle_oe, input bit busy_token);
        logic [10:0] base;
        logic [11:0] exp;
        base = 11'((c - 3'd1) * 256 + (b - 3'd1) * 64);
        send_token(c, b);
        check("R3 first request", 32'(rd_en), 1);
        check("R2 first address", 32'(rd_addr), 32'(base));
        check("R4 bus empty at request", 32'(bus_valid), 0);
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            oe_n = toggle_oe ? i[0] : 1'b0;
            if (busy_token && i == 5) begin
                chan_sel = 3'd6;
                blk_code = 3'd5;
                tok_in   = 1'b1;
            end
            if (busy_token && i == 6) begin
                check("R11 no monitor clear", 32'(clr_mon), 0);
                check("R11 no token clear", 32'(clr_tok), 0);
                tok_in = 1'b0;
            end
            #1;
            exp = mem_word(base + 11'(i));
            check("R4 bus_valid", 32'(bus_valid), 1);
            check("R6 bus_oe", 32'(bus_oe), 32'(!oe_n));
            check("R2 R6 bus_data", 32'(bus_data), oe_n ? 32'd0 : 32'(exp));
            check("R5 no early token", 32'(tok_out), 0);
            if (i == 61) check("R3 request still high", 32'(rd_en), 1);
            if (i == 62) check("R3 requests stopped", 32'(rd_en), 0);
        end
        oe_n = 1'b0;
        @(negedge clk);
        check("R5 token after last word", 32'(tok_out), 1);
        check("R4 bus empty after block", 32'(bus_valid), 0);
        @(negedge clk);
        check("R5 token one cycle", 32'(tok_out), 0);
    endtask

    task automatic t_cmd(input string tag, input logic [2:0] c, input logic [2:0] b,
                         input logic mon, input logic tok, input logic trig, input logic pass);
        send_token(c, b);
        check({tag, " clr_mon"}, 32'(clr_mon), 32'(mon));
        check({tag, " clr_tok"}, 32'(clr_tok), 32'(tok));
        check({tag, " clr_trig"}, 32'(clr_trig), 32'(trig));
        check({tag, " tok_out"}, 32'(tok_out), 32'(pass));
        check({tag, " no read"}, 32'(rd_en), 0);
        @(negedge clk);
        quiet_outputs({tag, " next cycle"});
        @(negedge clk);
        check({tag, " still no bus word"}, 32'(bus_valid), 0);
    endtask

    initial begin
        t_reset();
        t_read(3'd1, 3'd1, 1'b0, 1'b0);
        t_read(3'd5, 3'd4, 1'b0, 1'b0);
        t_read(3'd3, 3'd2, 1'b1, 1'b1);
        t_cmd("R7 monitor", 3'd6, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1);
        t_cmd("R8 token clear", 3'd3, 3'd5, 1'b0, 1'b1, 1'b0, 1'b1);
        t_cmd("R8 trigger clear", 3'd2, 3'd6, 1'b0, 1'b0, 1'b1, 1'b1);
        t_cmd("R9 no channel", 3'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        t_cmd("R9 no block", 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        t_cmd("R10 channel seven", 3'd7, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        t_cmd("R10 block seven", 3'd3, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
        t_cmd("R10 seven with clear", 3'd6, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
        t_read(3'd2, 3'd3, 1'b0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule